// File: doc/BRIEF.md
# Drive Password Lock Controller

This block sequences the password security state of a storage device. A host command is presented as a decoded opcode together with two qualifier bits: one that picks the master or the user password, and one that picks the security level. The block answers every command with exactly one completion pulse or one abort pulse. It keeps the lock, enable, freeze and security-level state, and it counts failed unlock attempts.

Password storage, the password comparison itself and the media erase all sit outside the block. When a command needs a password check, the block raises a request toward an external comparator and waits for that comparator's result strobe. A successful erase-unit command raises a one-cycle go pulse that starts the external erase engine.

At reset the block loads the lock, enable and level state from two boot inputs. These inputs stand for the password state that was kept across the power cycle.

Top module: `sec_lock_ctrl`

## Requirements
- R1: While reset (active low, synchronous) is asserted, and on the first cycle after it, the block drives: locked = enabled = boot_pw_set, frozen = 0, expired = 0, attempt counter = 5, no pending erase-prepare, and cmp_req, cmd_done, cmd_abort and erase_go all low.
- R2: Opcodes decode as follows: F1h set-password, F2h unlock, F3h erase-prepare, F4h erase-unit, F5h freeze-lock, F6h disable-password. A command is taken when cmd_valid is high and cmp_req is low. A command that needs no password check gets exactly one cmd_done or cmd_abort pulse in the next cycle. For unlock, erase-unit and disable-password, when no immediate abort applies, cmp_req rises in the next cycle and stays high until a cycle with cmp_valid high. The response pulse (cmd_done if cmp_match is 1, otherwise cmd_abort) follows one cycle after that strobe, and cmp_req drops in the same cycle.
- R3: An unlock whose compare fails is aborted. If the device is locked, the attempt counter drops by one. If the device is not locked, the counter is unchanged. An unlock whose compare matches clears locked.
- R4: When the attempt counter reaches zero, st_expired goes high. From then until reset, every unlock and every erase-unit is aborted in the cycle after decode, with no compare request.
- R5: A freeze-lock completes and sets frozen, unless the device is locked, in which case it is aborted. A freeze-lock issued while already frozen completes. Frozen is cleared only by reset. While frozen, set-password, unlock, erase-prepare, erase-unit and disable-password are aborted immediately.
- R6: An erase-unit is aborted immediately unless the command taken just before it was an erase-prepare that completed. Any other command taken in between cancels the pending prepare.
- R7: An erase-unit whose compare fails is aborted. It does not change the counter, does not pulse erase_go, and leaves locked and enabled unchanged.
- R8: An erase-unit whose compare matches pulses erase_go in the same cycle as cmd_done. In that cycle it clears locked and enabled, selects the high security level, and reloads the counter to 5.
- R9: An unlock with cmd_ident = 1 (master) is aborted immediately, with no compare request, when the maximum level is selected (level bit = 1). At the high level (level bit = 0), it goes through a compare like a user unlock.
- R10: A disable-password whose compare matches clears both enabled and locked. A mismatch aborts it with no state change.
- R11: A set-password is aborted while the device is locked. Otherwise it completes. With cmd_ident = 0 (user) it sets enabled and stores cmd_level as the security level (1 = maximum). With cmd_ident = 1 it changes no state.
- R12: Any other opcode completes in the next cycle and changes no state except cancelling a pending prepare. cmp_valid has no effect while cmp_req is low. cmd_valid has no effect while cmp_req is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_pw_set | input | 1 | A user password was stored before power-up (loaded into locked and enabled during reset) |
| boot_lvl_max | input | 1 | The stored security level is maximum (loaded during reset) |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_ident | input | 1 | Password identifier: 0 user, 1 master |
| cmd_level | input | 1 | Security level for set-password: 0 high, 1 maximum |
| cmp_valid | input | 1 | Password compare result strobe |
| cmp_match | input | 1 | Compare result, valid with cmp_valid |
| cmp_req | output | 1 | Waiting for a password compare |
| erase_go | output | 1 | One-cycle start pulse for the media erase |
| cmd_done | output | 1 | Command completed |
| cmd_abort | output | 1 | Command aborted |
| st_locked | output | 1 | Device locked |
| st_frozen | output | 1 | Device frozen |
| st_enabled | output | 1 | User password enabled |
| st_expired | output | 1 | Attempt counter exhausted |

## Verification
Most of this block's state is visible on the status pins. The attempt counter and the pending prepare flag are not; they show up only through later responses. A wrong counter value appears when st_expired rises too early or too late, or when a later unlock or erase is aborted without a compare request. A lost or stale prepare flag appears one command later, as the wrong response to the erase-unit that follows. The bench therefore compares every response pulse and status bit against a behavioural model on every clock. Its scenarios are built so that each hidden state reaches a port within a few commands.

// File: rtl/sec_pkg.sv
// Shared opcodes, command classes and state bundle for the password lock controller.
// Assumes 8-bit opcodes presented already decoded from the host command block.
package sec_pkg;
    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OP_SET_PW   = 8'hF1;
    localparam logic [OP_W-1:0] OP_UNLOCK   = 8'hF2;
    localparam logic [OP_W-1:0] OP_PREPARE  = 8'hF3;
    localparam logic [OP_W-1:0] OP_ERASE    = 8'hF4;
    localparam logic [OP_W-1:0] OP_FREEZE   = 8'hF5;
    localparam logic [OP_W-1:0] OP_DISABLE  = 8'hF6;

    // Command class after opcode decode.
    typedef enum logic [2:0] {
        K_OTHER,
        K_SET_PW,
        K_UNLOCK,
        K_PREPARE,
        K_ERASE,
        K_FREEZE,
        K_DISABLE
    } cmd_kind_t;

    // First-cycle response chosen at decode.
    typedef enum logic [1:0] {
        RSP_DONE,
        RSP_ABORT,
        RSP_CMP
    } rsp_t;

    // Security state seen by the decoder.
    typedef struct packed {
        logic locked;
        logic enabled;
        logic frozen;
        logic lvl_max;
        logic prep;
        logic expired;
    } sec_state_t;
endpackage

// File: rtl/sec_cmd_decode.sv
// Classifies an opcode and picks its first-cycle response from the current
// security state: complete, abort, or wait for a password compare.
// Purely combinational; assumes the state inputs are registered upstream.
module sec_cmd_decode
    import sec_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            ident_master,
    input  sec_state_t      st,
    output cmd_kind_t       kind,
    output rsp_t            rsp
);

    // Map opcode to command class.
    always_comb begin
        case (op)
            OP_SET_PW:  kind = K_SET_PW;
            OP_UNLOCK:  kind = K_UNLOCK;
            OP_PREPARE: kind = K_PREPARE;
            OP_ERASE:   kind = K_ERASE;
            OP_FREEZE:  kind = K_FREEZE;
            OP_DISABLE: kind = K_DISABLE;
            default:    kind = K_OTHER;
        endcase
    end

    // Apply the gating rules for each class.
    always_comb begin
        case (kind)
            K_SET_PW:
                rsp = (st.frozen || st.locked) ? RSP_ABORT : RSP_DONE;
            K_UNLOCK:
                rsp = (st.frozen || st.expired || (ident_master && st.lvl_max))
                      ? RSP_ABORT : RSP_CMP;
            K_PREPARE:
                rsp = st.frozen ? RSP_ABORT : RSP_DONE;
            K_ERASE:
                rsp = (st.frozen || st.expired || !st.prep) ? RSP_ABORT : RSP_CMP;
            K_FREEZE:
                rsp = st.locked ? RSP_ABORT : RSP_DONE;
            K_DISABLE:
                rsp = st.frozen ? RSP_ABORT : RSP_CMP;
            default:
                rsp = RSP_DONE;
        endcase
    end

endmodule

// File: rtl/sec_try_counter.sv
// Failed-unlock attempt counter. Loads LIMIT on reset or reload, counts down
// on each decrement request, saturates at zero and flags exhaustion.
// Assumes reload and dec are never requested in the same cycle.
module sec_try_counter #(
    parameter  int LIMIT = 5,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic dec,
    output logic expired
);

    logic [CW-1:0] cnt_q;

    // Hold the remaining attempt count.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            cnt_q <= CW'(LIMIT);
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Exhaustion flag.
    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sec_lock_ctrl.sv
// Password lock controller top. Takes one command at a time. When a password
// check is needed it holds cmp_req until the comparator strobes cmp_valid,
// then answers. Assumes the host does not issue commands while cmp_req is
// high (any that are issued are ignored) and that the comparator result
// belongs to the pending command.
module sec_lock_ctrl
    import sec_pkg::*;
#(
    parameter int TRY_LIMIT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boot_pw_set,
    input  logic            boot_lvl_max,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            cmd_ident,
    input  logic            cmd_level,
    input  logic            cmp_valid,
    input  logic            cmp_match,
    output logic            cmp_req,
    output logic            erase_go,
    output logic            cmd_done,
    output logic            cmd_abort,
    output logic            st_locked,
    output logic            st_frozen,
    output logic            st_enabled,
    output logic            st_expired
);

    logic       locked_q, enabled_q, frozen_q, lvl_max_q, prep_q;
    logic       wait_q, done_q, abort_q, erase_q;
    cmd_kind_t  pend_q;
    cmd_kind_t  dec_kind;
    rsp_t       dec_rsp;
    sec_state_t cur_st;
    logic       expired;
    logic       accept, resolve, cnt_dec, cnt_reload;

    // Bundle state for the decoder.
    assign cur_st = '{locked: locked_q, enabled: enabled_q, frozen: frozen_q,
                      lvl_max: lvl_max_q, prep: prep_q, expired: expired};

    sec_cmd_decode u_decode (
        .op           (cmd_op),
        .ident_master (cmd_ident),
        .st           (cur_st),
        .kind         (dec_kind),
        .rsp          (dec_rsp)
    );

    // Command acceptance and compare resolution strobes.
    assign accept  = cmd_valid && !wait_q;
    assign resolve = wait_q && cmp_valid;

    // Counter controls: failed locked unlock decrements, good erase reloads.
    assign cnt_dec    = resolve && (pend_q == K_UNLOCK) && !cmp_match && locked_q;
    assign cnt_reload = resolve && (pend_q == K_ERASE) && cmp_match;

    sec_try_counter #(.LIMIT(TRY_LIMIT)) u_tries (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (cnt_reload),
        .dec     (cnt_dec),
        .expired (expired)
    );

    // Security state, pending command and response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q  <= boot_pw_set;
            enabled_q <= boot_pw_set;
            lvl_max_q <= boot_lvl_max;
            frozen_q  <= 1'b0;
            prep_q    <= 1'b0;
            wait_q    <= 1'b0;
            pend_q    <= K_OTHER;
            done_q    <= 1'b0;
            abort_q   <= 1'b0;
            erase_q   <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            erase_q <= 1'b0;
            if (resolve) begin
                wait_q <= 1'b0;
                if (cmp_match) begin
                    done_q <= 1'b1;
                    case (pend_q)
                        K_UNLOCK: locked_q <= 1'b0;
                        K_ERASE: begin
                            locked_q  <= 1'b0;
                            enabled_q <= 1'b0;
                            lvl_max_q <= 1'b0;
                            erase_q   <= 1'b1;
                        end
                        K_DISABLE: begin
                            locked_q  <= 1'b0;
                            enabled_q <= 1'b0;
                        end
                        default: ;
                    endcase
                end else begin
                    abort_q <= 1'b1;
                end
            end else if (accept) begin
                prep_q <= (dec_kind == K_PREPARE) && (dec_rsp == RSP_DONE);
                case (dec_rsp)
                    RSP_DONE: begin
                        done_q <= 1'b1;
                        if (dec_kind == K_SET_PW && !cmd_ident) begin
                            enabled_q <= 1'b1;
                            lvl_max_q <= cmd_level;
                        end
                        if (dec_kind == K_FREEZE) begin
                            frozen_q <= 1'b1;
                        end
                    end
                    RSP_ABORT: abort_q <= 1'b1;
                    default: begin
                        wait_q <= 1'b1;
                        pend_q <= dec_kind;
                    end
                endcase
            end
        end
    end

    // Port drive.
    assign cmp_req    = wait_q;
    assign erase_go   = erase_q;
    assign cmd_done   = done_q;
    assign cmd_abort  = abort_q;
    assign st_locked  = locked_q;
    assign st_frozen  = frozen_q;
    assign st_enabled = enabled_q;
    assign st_expired = expired;

endmodule

// File: rtl/sec_lock_ctrl_chk.sv
// Port-level temporal checks for the password lock controller, bound to the top.
module sec_lock_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmp_valid,
    input logic       cmp_req,
    input logic       erase_go,
    input logic       cmd_done,
    input logic       cmd_abort,
    input logic       st_locked,
    input logic       st_enabled,
    input logic       st_frozen,
    input logic       st_expired
);

    // R2
    one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && cmd_abort));

    // R2
    cmp_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && cmp_valid) |=> ((cmd_done || cmd_abort) && !cmp_req));

    // R2
    decode_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmp_req) |=> (cmd_done || cmd_abort || cmp_req));

    // R5
    frozen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_frozen |=> st_frozen);

    // R4
    expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_expired |=> st_expired);

    // R8
    erase_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> (cmd_done && !st_locked && !st_enabled));

    // R12
    stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_req && cmp_valid && !cmd_valid) |=> (!cmd_done && !cmd_abort));

endmodule

bind sec_lock_ctrl sec_lock_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmp_valid  (cmp_valid),
    .cmp_req    (cmp_req),
    .erase_go   (erase_go),
    .cmd_done   (cmd_done),
    .cmd_abort  (cmd_abort),
    .st_locked  (st_locked),
    .st_enabled (st_enabled),
    .st_frozen  (st_frozen),
    .st_expired (st_expired)
);

// File: tb/sec_lock_ctrl_bench.sv
// Self-checking bench: behavioural reference compared on every clock plus
// directed checks per requirement.
module sec_lock_ctrl_bench;
    localparam time CLK_P = 4ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_pw_set = 1'b1, boot_lvl_max = 1'b0;
    logic       cmd_valid = 1'b0, cmd_ident = 1'b0, cmd_level = 1'b0;
    logic [7:0] cmd_op = 8'h00;
    logic       cmp_valid = 1'b0, cmp_match = 1'b0;
    logic       cmp_req, erase_go, cmd_done, cmd_abort;
    logic       st_locked, st_frozen, st_enabled, st_expired;

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    finished = 0;

    always #(CLK_P/2) clk = ~clk;

    sec_lock_ctrl u_sec_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .boot_pw_set(boot_pw_set), .boot_lvl_max(boot_lvl_max),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ident(cmd_ident), .cmd_level(cmd_level),
        .cmp_valid(cmp_valid), .cmp_match(cmp_match), .cmp_req(cmp_req), .erase_go(erase_go),
        .cmd_done(cmd_done), .cmd_abort(cmd_abort), .st_locked(st_locked),
        .st_frozen(st_frozen), .st_enabled(st_enabled), .st_expired(st_expired)
    );

    // Reference model state
    int m_tries, m_locked, m_enabled, m_frozen, m_lvl, m_prep, m_wait, m_pend;
    int e_done, e_abort, e_erase;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tries = 5; m_locked = boot_pw_set; m_enabled = boot_pw_set;
            m_lvl = boot_lvl_max; m_frozen = 0; m_prep = 0; m_wait = 0; m_pend = 0;
            e_done = 0; e_abort = 0; e_erase = 0;
        end else begin
            e_done = 0; e_abort = 0; e_erase = 0;
            if (m_wait != 0 && cmp_valid) begin
                m_wait = 0;
                if (cmp_match) begin
                    e_done = 1;
                    if (m_pend == 'hF2) m_locked = 0;
                    if (m_pend == 'hF4) begin
                        m_locked = 0; m_enabled = 0; m_lvl = 0; m_tries = 5; e_erase = 1;
                    end
                    if (m_pend == 'hF6) begin m_locked = 0; m_enabled = 0; end
                end else begin
                    e_abort = 1;
                    if (m_pend == 'hF2 && m_locked != 0 && m_tries > 0) m_tries--;
                end
            end else if (m_wait == 0 && cmd_valid) begin
                int nprep;
                nprep = 0;
                case (cmd_op)
                    8'hF1: if (m_frozen != 0 || m_locked != 0) e_abort = 1;
                           else begin
                               e_done = 1;
                               if (!cmd_ident) begin m_enabled = 1; m_lvl = cmd_level; end
                           end
                    8'hF2: if (m_frozen != 0 || m_tries == 0 || (cmd_ident && m_lvl != 0)) e_abort = 1;
                           else begin m_wait = 1; m_pend = 'hF2; end
                    8'hF3: if (m_frozen != 0) e_abort = 1; else begin e_done = 1; nprep = 1; end
                    8'hF4: if (m_frozen != 0 || m_tries == 0 || m_prep == 0) e_abort = 1;
                           else begin m_wait = 1; m_pend = 'hF4; end
                    8'hF5: if (m_locked != 0) e_abort = 1; else begin e_done = 1; m_frozen = 1; end
                    8'hF6: if (m_frozen != 0) e_abort = 1;
                           else begin m_wait = 1; m_pend = 'hF6; end
                    default: e_done = 1;
                endcase
                m_prep = nprep;
            end
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (!finished) begin
            logic [7:0] act, exp;
            act = {cmp_req, erase_go, cmd_done, cmd_abort, st_locked, st_frozen, st_enabled, st_expired};
            exp = {m_wait != 0, e_erase != 0, e_done != 0, e_abort != 0, m_locked != 0,
                   m_frozen != 0, m_enabled != 0, m_tries == 0};
            checks++;
            if (act !== exp) begin
                errors++;
                $display("FAIL %s model compare at %0t: actual %b expected %b (req,go,done,abort,lock,frz,en,exp)",
                         cur_req, $time, act, exp);
            end
        end
    end

    // Response monitor for directed checks.
    int last_rsp = 0;
    bit saw_creq = 0, saw_go = 0;
    always @(negedge clk) begin
        if (cmd_done) last_rsp = 1;
        if (cmd_abort) last_rsp = 2;
        if (cmp_req) saw_creq = 1;
        if (erase_go) saw_go = 1;
    end

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run(input logic [7:0] op, input logic id, input logic lv,
                       input bit use_cmp, input logic match);
        @(negedge clk);
        last_rsp = 0; saw_creq = 0; saw_go = 0;
        cmd_valid = 1; cmd_op = op; cmd_ident = id; cmd_level = lv;
        @(negedge clk);
        cmd_valid = 0;
        if (use_cmp) begin
            cmp_valid = 1; cmp_match = match;
            @(negedge clk);
            cmp_valid = 0;
        end
        idle(2);
    endtask

    task automatic do_reset(input logic pw, input logic lv);
        @(negedge clk);
        boot_pw_set = pw; boot_lvl_max = lv; rst_n = 0;
        idle(2);
        rst_n = 1;
        idle(1);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Phase A: boot locked, high level
        cur_req = "R1";
        do_reset(1, 0);
        chk("R1 locked", st_locked, 1);
        chk("R1 enabled", st_enabled, 1);
        chk("R1 frozen", st_frozen, 0);
        chk("R1 expired", st_expired, 0);
        chk("R1 pulses", {cmd_done, cmd_abort, cmp_req, erase_go}, 0);

        cur_req = "R11";
        run(8'hF1, 0, 0, 0, 0);
        chk("R11 set while locked", last_rsp, 2);

        cur_req = "R9";
        run(8'hF2, 1, 0, 1, 0);
        chk("R9 master high compared", saw_creq, 1);
        chk("R9 master mismatch", last_rsp, 2);

        cur_req = "R3";
        for (int i = 0; i < 3; i++) run(8'hF2, 0, 0, 1, 0);
        chk("R3 still locked", st_locked, 1);
        chk("R3 one try left", st_expired, 0);
        run(8'hF2, 0, 0, 1, 1);
        chk("R3 unlock done", last_rsp, 1);
        chk("R3 unlocked", st_locked, 0);
        run(8'hF2, 0, 0, 1, 0);
        chk("R3 unlocked miss abort", last_rsp, 2);
        chk("R3 no decrement when unlocked", st_expired, 0);

        cur_req = "R6";
        run(8'hF3, 0, 0, 0, 0);
        run(8'h00, 0, 0, 0, 0);
        run(8'hF4, 0, 0, 0, 0);
        chk("R6 prepare cancelled", last_rsp, 2);
        chk("R6 no compare", saw_creq, 0);
        run(8'hF4, 0, 0, 0, 0);
        chk("R6 erase without prepare", last_rsp, 2);

        cur_req = "R7";
        run(8'hF3, 0, 0, 0, 0);
        run(8'hF4, 0, 0, 1, 0);
        chk("R7 erase mismatch", last_rsp, 2);
        chk("R7 no erase_go", saw_go, 0);
        chk("R7 enabled kept", st_enabled, 1);

        cur_req = "R8";
        run(8'hF3, 0, 0, 0, 0);
        run(8'hF4, 0, 0, 1, 1);
        chk("R8 erase done", last_rsp, 1);
        chk("R8 erase_go", saw_go, 1);
        chk("R8 enabled cleared", st_enabled, 0);
        chk("R8 counter reloaded", st_expired, 0);

        cur_req = "R11";
        run(8'hF1, 1, 1, 0, 0);
        chk("R11 master set done", last_rsp, 1);
        chk("R11 master set no enable", st_enabled, 0);
        run(8'hF1, 0, 1, 0, 0);
        chk("R11 user set enables", st_enabled, 1);

        cur_req = "R9";
        run(8'hF2, 1, 0, 0, 0);
        chk("R9 master at max refused", last_rsp, 2);
        chk("R9 no compare at max", saw_creq, 0);

        cur_req = "R10";
        run(8'hF6, 0, 0, 1, 0);
        chk("R10 disable mismatch", last_rsp, 2);
        chk("R10 enabled kept", st_enabled, 1);
        run(8'hF6, 0, 0, 1, 1);
        chk("R10 disable match", last_rsp, 1);
        chk("R10 enabled cleared", st_enabled, 0);

        cur_req = "R12";
        run(8'h42, 0, 0, 0, 0);
        chk("R12 other opcode done", last_rsp, 1);
        @(negedge clk);
        last_rsp = 0;
        cmp_valid = 1; cmp_match = 1;
        @(negedge clk);
        cmp_valid = 0;
        idle(2);
        chk("R12 stray strobe ignored", last_rsp, 0);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 8'hF2; cmd_ident = 0;
        @(negedge clk);
        cmd_op = 8'hF5;
        @(negedge clk);
        cmd_valid = 0;
        cmp_valid = 1; cmp_match = 1;
        @(negedge clk);
        cmp_valid = 0;
        idle(2);
        chk("R12 command during wait ignored", st_frozen, 0);

        // Phase B: boot locked, maximum level
        cur_req = "R1";
        do_reset(1, 1);
        chk("R1 relocked", st_locked, 1);
        cur_req = "R9";
        run(8'hF2, 1, 0, 0, 0);
        chk("R9 max master refused", last_rsp, 2);
        chk("R9 max no compare", saw_creq, 0);
        cur_req = "R4";
        for (int i = 0; i < 5; i++) run(8'hF2, 0, 0, 1, 0);
        chk("R4 expired", st_expired, 1);
        run(8'hF2, 0, 0, 0, 0);
        chk("R4 unlock refused", last_rsp, 2);
        chk("R4 unlock no compare", saw_creq, 0);
        run(8'hF3, 0, 0, 0, 0);
        run(8'hF4, 0, 0, 0, 0);
        chk("R4 erase refused", last_rsp, 2);
        chk("R4 erase no compare", saw_creq, 0);
        cur_req = "R5";
        run(8'hF5, 0, 0, 0, 0);
        chk("R5 freeze while locked", last_rsp, 2);
        chk("R5 not frozen", st_frozen, 0);

        // Phase C: boot unlocked, freeze
        do_reset(0, 0);
        chk("R1 expired cleared by reset", st_expired, 0);
        cur_req = "R5";
        run(8'hF5, 0, 0, 0, 0);
        chk("R5 freeze done", last_rsp, 1);
        chk("R5 frozen", st_frozen, 1);
        run(8'hF5, 0, 0, 0, 0);
        chk("R5 refreeze done", last_rsp, 1);
        run(8'hF1, 0, 0, 0, 0);
        chk("R5 set refused", last_rsp, 2);
        run(8'hF2, 0, 0, 0, 0);
        chk("R5 unlock refused", last_rsp, 2);
        run(8'hF3, 0, 0, 0, 0);
        chk("R5 prepare refused", last_rsp, 2);
        run(8'hF6, 0, 0, 0, 0);
        chk("R5 disable refused", last_rsp, 2);
        run(8'h00, 0, 0, 0, 0);
        chk("R5 still frozen", st_frozen, 1);
        cur_req = "R1";
        do_reset(0, 0);
        chk("R1 reset unfreezes", st_frozen, 0);
        idle(3);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule